// File: doc/BRIEF.md
# Thread Select Controller for a Shared Pipeline

This block decides, every clock, which hardware thread feeds the next instruction into one shared pipeline. It keeps a program counter for each thread and offers the chosen thread's ID and PC on its output. It has two switching policies. In fine-grained mode it rotates through the threads every cycle and passes over any thread that cannot issue. In coarse-grained mode it stays with one thread until that thread reports a costly stall, such as a second-level cache miss. It then requests a pipeline flush and moves to another thread. A refill counter keeps completion blocked while the new thread's instructions travel through the pipeline.

A thread that reports a costly stall is parked. It takes no part in selection, in either mode, until its stall-done input pulses. The issue output is valid-only and has no ready input. Back-pressure from the pipeline comes in through the per-thread short-stall flags. When the pipeline cannot accept a thread, it raises that thread's flag and the block either skips the thread or holds. No PC moves in a cycle with `issue_valid_o` low.

Top module: `thread_select_ctrl`

## Requirements
- R1: After reset, thread t's PC is 0x1000 + t*0x1000, fine-grained mode is active, the first instruction issues from thread 0, `flush_o` is low and `commit_ok_o` is high.
- R2: In fine-grained mode, each issue picks the first thread in rotating order that follows the last issued thread.
- R3: In fine-grained mode, a thread is skipped if its short-stall or long-stall input is high or if it is parked.
- R4: When no thread can issue, `issue_valid_o` is low and no PC advances.
- R5: In coarse-grained mode, the current thread keeps issuing while it is neither long-stalled nor parked. A short stall of the current thread lowers `issue_valid_o` and does not cause a switch.
- R6: In coarse-grained mode, when the current thread is long-stalled or parked and another thread is eligible, `flush_o` is high for that cycle and nothing issues. From the next cycle the current thread is the first eligible thread, in rotating order, after the stalled one.
- R7: In coarse-grained mode, when the current thread is blocked and no other thread is eligible, the block idles with no issue and no flush. It switches as soon as a thread becomes eligible.
- R8: After a flush cycle, `commit_ok_o` is low for exactly REFILL cycles and then returns high.
- R9: A thread becomes parked in the cycle after its long-stall input is high. It stays parked until a cycle in which its stall-done input is high and its long-stall input is low.
- R10: `fetch_pc_o` is the PC of the thread on `thread_id_o`. Each issue adds 4 to that thread's PC only.
- R11: A change on `coarse_mode_i` takes effect only at a switch point. Fine to coarse applies at the next clock edge. Coarse to fine applies only at the edge that ends a flush cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| coarse_mode_i | input | 1 | 1 requests coarse-grained switching, 0 requests fine-grained |
| short_stall_i | input | NTHR | Per-thread short stall; the thread cannot issue this cycle |
| long_stall_i | input | NTHR | Per-thread costly stall; parks the thread |
| stall_done_i | input | NTHR | Per-thread pulse that releases a parked thread |
| thread_id_o | output | clog2(NTHR) | Selected (or current) thread |
| fetch_pc_o | output | PC_W | PC of the thread on `thread_id_o` |
| issue_valid_o | output | 1 | An instruction from `thread_id_o` issues this cycle |
| flush_o | output | 1 | Pipeline flush request on a coarse-grained switch |
| commit_ok_o | output | 1 | Low while the pipeline refills after a flush |

## Verification
The hardest cases to reach are the coarse-grained corners. One is the idle state in which the current thread is blocked and every other thread is parked. Another is a long stall that arrives in the same cycle as that thread's stall-done pulse. The stimulus first gets to coarse mode through a fine-grained cycle. It then raises long stalls on both threads together, and releases them one at a time so that the switch happens only when a target exists. A mode request that arrives while the block is in coarse mode is held across several cycles to show it waits for the next flush.

// File: rtl/tsel_pkg.sv
package tsel_pkg;
  typedef enum logic {
    MODE_FINE   = 1'b0,
    MODE_COARSE = 1'b1
  } tsel_mode_e;
endpackage

// File: rtl/tsel_rr_pick.sv
module tsel_rr_pick #(
  parameter int unsigned N = 2,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] ptr,
  output logic [IW-1:0] pick,
  output logic          found
);
  // Scan from ptr+1 around to ptr; the nearest requester wins.
  always_comb begin
    pick  = ptr;
    found = 1'b0;
    for (int i = N; i >= 1; i--) begin
      int idx;
      idx = (int'(ptr) + i) % N;
      if (req[idx]) begin
        pick  = IW'(idx);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/tsel_pc_bank.sv
module tsel_pc_bank #(
  parameter int unsigned NTHR = 2,
  parameter int unsigned PC_W = 32,
  parameter logic [PC_W-1:0] PC_BASE = 'h1000,
  parameter logic [PC_W-1:0] PC_STRIDE = 'h1000,
  parameter int unsigned PC_STEP = 4,
  localparam int unsigned IW = $clog2(NTHR)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NTHR-1:0] adv,
  input  logic [IW-1:0]   rd_id,
  output logic [PC_W-1:0] rd_pc
);
  logic [NTHR*PC_W-1:0] pc_flat;

  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    logic [PC_W-1:0] pc_r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pc_r <= PC_BASE + PC_STRIDE * PC_W'(t);
      else if (adv[t]) pc_r <= pc_r + PC_W'(PC_STEP);
    end
    assign pc_flat[t*PC_W +: PC_W] = pc_r;
  end

  assign rd_pc = pc_flat[int'(rd_id)*PC_W +: PC_W];
endmodule

// File: rtl/tsel_refill.sv
module tsel_refill #(
  parameter int unsigned DEPTH = 3,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic busy
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= CW'(DEPTH);
    else if (cnt_q != '0)  cnt_q <= cnt_q - CW'(1);
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/thread_select_ctrl.sv
module thread_select_ctrl
  import tsel_pkg::*;
#(
  parameter int unsigned NTHR = 2,
  parameter int unsigned REFILL = 3,
  parameter int unsigned PC_W = 32,
  parameter logic [PC_W-1:0] PC_BASE = 'h1000,
  parameter logic [PC_W-1:0] PC_STRIDE = 'h1000,
  parameter int unsigned PC_STEP = 4,
  localparam int unsigned TID_W = $clog2(NTHR)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             coarse_mode_i,
  input  logic [NTHR-1:0]  short_stall_i,
  input  logic [NTHR-1:0]  long_stall_i,
  input  logic [NTHR-1:0]  stall_done_i,
  output logic [TID_W-1:0] thread_id_o,
  output logic [PC_W-1:0]  fetch_pc_o,
  output logic             issue_valid_o,
  output logic             flush_o,
  output logic             commit_ok_o
);
  tsel_mode_e       mode_q;
  logic [TID_W-1:0] cur_q;
  logic [NTHR-1:0]  parked_q;

  logic [NTHR-1:0]  ready, elig, adv;
  logic [TID_W-1:0] fine_id, sw_id, sel;
  logic             fine_hit, sw_hit, issue, flush, refill_busy;

  assign ready = ~short_stall_i & ~long_stall_i & ~parked_q;
  assign elig  = ~long_stall_i & ~parked_q;

  tsel_rr_pick #(.N(NTHR)) u_pick_fine (
    .req(ready), .ptr(cur_q), .pick(fine_id), .found(fine_hit)
  );

  tsel_rr_pick #(.N(NTHR)) u_pick_switch (
    .req(elig), .ptr(cur_q), .pick(sw_id), .found(sw_hit)
  );

  always_comb begin
    sel   = cur_q;
    issue = 1'b0;
    flush = 1'b0;
    if (mode_q == MODE_FINE) begin
      sel   = fine_id;
      issue = fine_hit;
    end else if (elig[cur_q]) begin
      issue = ~short_stall_i[cur_q];
    end else begin
      flush = sw_hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= MODE_FINE;
      cur_q    <= TID_W'(NTHR - 1);
      parked_q <= '0;
    end else begin
      parked_q <= long_stall_i | (parked_q & ~stall_done_i);
      if (flush)      cur_q <= sw_id;
      else if (issue) cur_q <= sel;
      if (mode_q == MODE_FINE || flush)
        mode_q <= tsel_mode_e'(coarse_mode_i);
    end
  end

  assign adv = issue ? (NTHR'(1) << sel) : '0;

  tsel_pc_bank #(
    .NTHR(NTHR), .PC_W(PC_W), .PC_BASE(PC_BASE),
    .PC_STRIDE(PC_STRIDE), .PC_STEP(PC_STEP)
  ) u_pcs (
    .clk(clk), .rst_n(rst_n), .adv(adv), .rd_id(sel), .rd_pc(fetch_pc_o)
  );

  tsel_refill #(.DEPTH(REFILL)) u_refill (
    .clk(clk), .rst_n(rst_n), .load(flush), .busy(refill_busy)
  );

  assign thread_id_o   = sel;
  assign issue_valid_o = issue;
  assign flush_o       = flush;
  assign commit_ok_o   = ~refill_busy;
endmodule

// File: rtl/thread_select_chk.sv
module thread_select_chk #(
  parameter int unsigned NTHR = 2,
  parameter int unsigned PC_W = 32,
  localparam int unsigned TID_W = $clog2(NTHR)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_q,
  input logic [NTHR-1:0]  short_stall_i,
  input logic [NTHR-1:0]  long_stall_i,
  input logic [TID_W-1:0] thread_id_o,
  input logic [PC_W-1:0]  fetch_pc_o,
  input logic             issue_valid_o,
  input logic             flush_o,
  input logic             commit_ok_o
);
  p_issue_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid_o |-> (!short_stall_i[thread_id_o] && !long_stall_i[thread_id_o]));

  p_coarse_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && issue_valid_o) |=> ((mode_q && issue_valid_o) |-> (thread_id_o == $past(thread_id_o))));

  p_switch_moves_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |=> (thread_id_o != $past(thread_id_o)));

  p_refill_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |=> !commit_ok_o);

  p_pc_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && issue_valid_o && $past(issue_valid_o) && thread_id_o == $past(thread_id_o))
      |-> (fetch_pc_o == $past(fetch_pc_o) + PC_W'(4)));
endmodule

bind thread_select_ctrl thread_select_chk #(.NTHR(NTHR), .PC_W(PC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_q(mode_q),
  .short_stall_i(short_stall_i), .long_stall_i(long_stall_i),
  .thread_id_o(thread_id_o), .fetch_pc_o(fetch_pc_o),
  .issue_valid_o(issue_valid_o), .flush_o(flush_o), .commit_ok_o(commit_ok_o)
);

// File: tb/thread_select_ctrl_tb.sv
module thread_select_ctrl_tb;
  localparam int NV = 39;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        coarse_mode_i;
  logic [1:0]  short_stall_i, long_stall_i, stall_done_i;
  logic [0:0]  thread_id_o;
  logic [31:0] fetch_pc_o;
  logic        issue_valid_o, flush_o, commit_ok_o;

  int checks = 0;
  int errors = 0;
  bit done_flag = 1'b0;

  always #4 clk = ~clk;

  thread_select_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .coarse_mode_i(coarse_mode_i),
    .short_stall_i(short_stall_i), .long_stall_i(long_stall_i),
    .stall_done_i(stall_done_i), .thread_id_o(thread_id_o),
    .fetch_pc_o(fetch_pc_o), .issue_valid_o(issue_valid_o),
    .flush_o(flush_o), .commit_ok_o(commit_ok_o)
  );

  // {req, mode, short, long, done, exp_tid, exp_valid, exp_flush, exp_commit, exp_pc}
  localparam logic [46:0] VEC [NV] = '{
    {4'd1, 1'b0,2'b00,2'b00,2'b00, 1'b0,1'b1,1'b0,1'b1, 32'h1000}, // R1 first issue
    {4'd2, 1'b0,2'b00,2'b00,2'b00, 1'b1,1'b1,1'b0,1'b1, 32'h2000}, // R2
    {4'd2, 1'b0,2'b00,2'b00,2'b00, 1'b0,1'b1,1'b0,1'b1, 32'h1004}, // R2
    {4'd3, 1'b0,2'b10,2'b00,2'b00, 1'b0,1'b1,1'b0,1'b1, 32'h1008}, // R3 skip short
    {4'd4, 1'b0,2'b11,2'b00,2'b00, 1'b0,1'b0,1'b0,1'b1, 32'h100C}, // R4 bubble
    {4'd2, 1'b0,2'b00,2'b00,2'b00, 1'b1,1'b1,1'b0,1'b1, 32'h2004}, // R2
    {4'd3, 1'b0,2'b00,2'b01,2'b00, 1'b1,1'b1,1'b0,1'b1, 32'h2008}, // R3 skip long
    {4'd9, 1'b0,2'b00,2'b00,2'b00, 1'b1,1'b1,1'b0,1'b1, 32'h200C}, // R9 parked
    {4'd9, 1'b0,2'b00,2'b00,2'b01, 1'b1,1'b1,1'b0,1'b1, 32'h2010}, // R9 release
    {4'd9, 1'b0,2'b00,2'b00,2'b00, 1'b0,1'b1,1'b0,1'b1, 32'h100C}, // R9 eligible again
    {4'd11,1'b1,2'b00,2'b00,2'b00, 1'b1,1'b1,1'b0,1'b1, 32'h2014}, // R11 still fine
    {4'd5, 1'b1,2'b00,2'b00,2'b00, 1'b1,1'b1,1'b0,1'b1, 32'h2018}, // R5 coarse stays
    {4'd10,1'b1,2'b00,2'b00,2'b00, 1'b1,1'b1,1'b0,1'b1, 32'h201C}, // R10
    {4'd5, 1'b1,2'b10,2'b00,2'b00, 1'b1,1'b0,1'b0,1'b1, 32'h2020}, // R5 short waits
    {4'd10,1'b1,2'b00,2'b00,2'b00, 1'b1,1'b1,1'b0,1'b1, 32'h2020}, // R10 no advance in wait
    {4'd6, 1'b1,2'b00,2'b10,2'b00, 1'b1,1'b0,1'b1,1'b1, 32'h2024}, // R6 flush
    {4'd8, 1'b1,2'b00,2'b00,2'b00, 1'b0,1'b1,1'b0,1'b0, 32'h1010}, // R8 refill
    {4'd8, 1'b1,2'b00,2'b00,2'b00, 1'b0,1'b1,1'b0,1'b0, 32'h1014}, // R8
    {4'd8, 1'b1,2'b00,2'b00,2'b00, 1'b0,1'b1,1'b0,1'b0, 32'h1018}, // R8
    {4'd8, 1'b1,2'b00,2'b00,2'b00, 1'b0,1'b1,1'b0,1'b1, 32'h101C}, // R8 window over
    {4'd11,1'b0,2'b00,2'b00,2'b00, 1'b0,1'b1,1'b0,1'b1, 32'h1020}, // R11 held coarse
    {4'd9, 1'b0,2'b00,2'b00,2'b10, 1'b0,1'b1,1'b0,1'b1, 32'h1024}, // R9 release t1
    {4'd11,1'b0,2'b00,2'b00,2'b00, 1'b0,1'b1,1'b0,1'b1, 32'h1028}, // R11 still coarse
    {4'd6, 1'b0,2'b00,2'b01,2'b00, 1'b0,1'b0,1'b1,1'b1, 32'h102C}, // R6 flush to t1
    {4'd11,1'b0,2'b00,2'b00,2'b00, 1'b1,1'b1,1'b0,1'b0, 32'h2024}, // R11 fine now
    {4'd8, 1'b0,2'b00,2'b00,2'b00, 1'b1,1'b1,1'b0,1'b0, 32'h2028}, // R8
    {4'd9, 1'b0,2'b00,2'b00,2'b01, 1'b1,1'b1,1'b0,1'b0, 32'h202C}, // R9
    {4'd2, 1'b0,2'b00,2'b00,2'b00, 1'b0,1'b1,1'b0,1'b1, 32'h102C}, // R2
    {4'd11,1'b1,2'b00,2'b00,2'b00, 1'b1,1'b1,1'b0,1'b1, 32'h2030}, // R11
    {4'd7, 1'b1,2'b00,2'b11,2'b00, 1'b1,1'b0,1'b0,1'b1, 32'h2034}, // R7 no target
    {4'd7, 1'b1,2'b00,2'b00,2'b00, 1'b1,1'b0,1'b0,1'b1, 32'h2034}, // R7 idle
    {4'd9, 1'b1,2'b00,2'b00,2'b01, 1'b1,1'b0,1'b0,1'b1, 32'h2034}, // R9
    {4'd6, 1'b1,2'b00,2'b00,2'b00, 1'b1,1'b0,1'b1,1'b1, 32'h2034}, // R6 late switch
    {4'd6, 1'b1,2'b00,2'b00,2'b00, 1'b0,1'b1,1'b0,1'b0, 32'h1030}, // R6
    {4'd9, 1'b1,2'b00,2'b01,2'b01, 1'b0,1'b0,1'b0,1'b0, 32'h1034}, // R9 long wins
    {4'd9, 1'b1,2'b00,2'b00,2'b00, 1'b0,1'b0,1'b0,1'b0, 32'h1034}, // R9 still parked
    {4'd9, 1'b1,2'b00,2'b00,2'b10, 1'b0,1'b0,1'b0,1'b1, 32'h1034}, // R9
    {4'd7, 1'b1,2'b00,2'b00,2'b00, 1'b0,1'b0,1'b1,1'b1, 32'h1034}, // R7 switch once eligible
    {4'd6, 1'b1,2'b00,2'b00,2'b00, 1'b1,1'b1,1'b0,1'b0, 32'h2034}  // R6
  };

  task automatic chk(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #100000;
    errors++;
    checks++;
    $display("FAIL R1 watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    coarse_mode_i = 1'b0;
    short_stall_i = '0;
    long_stall_i = '0;
    stall_done_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < NV; k++) begin
      logic [46:0] v;
      v = VEC[k];
      coarse_mode_i = v[42];
      short_stall_i = v[41:40];
      long_stall_i  = v[39:38];
      stall_done_i  = v[37:36];
      #2;
      chk(int'(v[46:43]), $sformatf("vec %0d tid", k), 32'(thread_id_o), 32'(v[35]));
      chk(int'(v[46:43]), $sformatf("vec %0d valid", k), 32'(issue_valid_o), 32'(v[34]));
      chk(int'(v[46:43]), $sformatf("vec %0d flush", k), 32'(flush_o), 32'(v[33]));
      chk(int'(v[46:43]), $sformatf("vec %0d commit", k), 32'(commit_ok_o), 32'(v[32]));
      chk(int'(v[46:43]), $sformatf("vec %0d pc", k), fetch_pc_o, v[31:0]);
      @(negedge clk);
    end
    // R1: reset in mid-run, with refill window active, restores start state
    coarse_mode_i = 1'b0;
    short_stall_i = '0;
    long_stall_i = '0;
    stall_done_i = '0;
    rst_n = 1'b0;
    #2;
    chk(1, "reset commit", 32'(commit_ok_o), 32'd1);
    chk(1, "reset flush", 32'(flush_o), 32'd0);
    chk(1, "reset pc", fetch_pc_o, 32'h1000);
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    chk(1, "post-reset tid", 32'(thread_id_o), 32'd0);
    chk(1, "post-reset valid", 32'(issue_valid_o), 32'd1);
    chk(1, "post-reset pc", fetch_pc_o, 32'h1000);
    @(negedge clk);
    #2;
    chk(1, "thread1 start pc", fetch_pc_o, 32'h2000); // R1
    chk(2, "alternate tid", 32'(thread_id_o), 32'd1); // R2
    @(negedge clk);
    finish_run();
  end
endmodule